// File: doc/BRIEF.md
# Horizontal Sync Output Generator

This block drives the horizontal sync pulse of a display back end. A pixel counter runs on the back-end clock. It starts a line each time it reloads to zero, and the output pulse is asserted for the first 64 counts of every line. In freerun mode the counter wraps at a programmed line length and ignores any incoming sync. In locked mode it also reloads on each rising edge of a horizontal sync recovered from the video input, so the output pulse follows that sync.

A watchdog on the input sync decides whether a usable signal is present. The signal is declared missing when no sync edge arrives for two programmed line lengths. It is declared present again only after four sync-to-sync spacings in a row land close to the programmed line length. When automatic fallback is enabled, a missing signal forces freerun operation whatever the mode bit says. Every change of the operating mode waits for a line boundary, so a pulse is never cut short.

Top module: `hsync_gen`

## Requirements
- R1: The output pulse is active for exactly 64 consecutive clock cycles, covering counter values 0 to 63 of each line.
- R2: In freerun operation the counter steps by one per clock and reloads to 0 after reaching `lineTotal`-1, so a line lasts `lineTotal` cycles. `lineTotal` must exceed 64.
- R3: In locked operation, a rising edge of `syncIn` sampled at a clock edge reloads the counter to 0 at that edge, so the output pulse starts in the following cycle. This happens whatever the counter's value was.
- R4: With `invertPol`=0 the pulse is high and idles low. With `invertPol`=1 the levels are swapped.
- R5: `freerunSel`=1 requests freerun and `freerunSel`=0 requests locked operation. While freerun is in effect, edges on `syncIn` do not move the counter.
- R6: A requested change of operating mode takes effect only at a counter reload (a wrap, or a locked sync reload). `freeActive` shows the mode in effect: 1 for freerun, 0 for locked.
- R7: `sigLost` rises at the clock edge 2×`lineTotal` cycles after the last rising sync edge if no further rising edge has arrived.
- R8: `sigLost` clears at the rising edge that completes four consecutive rise-to-rise spacings, each within `lineTotal`±16 cycles. A spacing outside that window restarts the run. The first edge after reset or after a loss does not count.
- R9: With `autoFreeEn`=1 and `sigLost`=1, freerun is requested regardless of `freerunSel`. With `autoFreeEn`=0, only `freerunSel` decides.
- R10: After reset the counter is 0, the output is at its active level, `freeActive`=1 and `sigLost`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Back-end pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| freerunSel | input | 1 | Mode request: 1 freerun, 0 locked |
| autoFreeEn | input | 1 | Enables automatic freerun on signal loss |
| invertPol | input | 1 | 1 makes the output pulse active low |
| lineTotal | input | 12 | Pixels per line (line length in clocks) |
| syncIn | input | 1 | Horizontal sync recovered from the video input |
| hsyncOut | output | 1 | Horizontal sync output pulse |
| freeActive | output | 1 | Operating mode in effect: 1 freerun |
| sigLost | output | 1 | Input sync considered missing |

## Verification
The output level is combinational from the counter, so after N clock edges since reset release, or since a sync reload edge, the output reflects counter value N mod `lineTotal`. A sync driven before an edge reloads at that same edge. `sigLost` and `freeActive` are registers that change at the deciding edge itself: the edge of the qualifying sync for clearing, the edge 2×`lineTotal` after the last sync for loss, and the reload edge for a mode change. The bench counts falling edges from each known event and samples there, one edge before and one edge after each deciding moment.

// File: rtl/hsync_pkg.sv
package hsync_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic reload;   // counter returns to zero at this edge
    logic syncHit;  // reload caused by an input sync in locked operation
  } hsync_stb_t;
endpackage

// File: rtl/hsync_ctrl.sv
module hsync_ctrl
  import hsync_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int TOL      = 16,
  parameter int GOOD_RUN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             freerunSel,
  input  logic             autoFreeEn,
  input  logic [CNT_W-1:0] lineTotal,
  input  logic             syncIn,
  input  logic             lineEnd,
  output hsync_stb_t       stb,
  output logic             freeActive,
  output logic             sigLost
);
  localparam int GAP_W  = CNT_W + 2;
  localparam int SPAN_W = GAP_W + 1;
  localparam int GOOD_W = $clog2(GOOD_RUN + 1);
  localparam logic [GAP_W-1:0]  GAP_MAX  = '1;
  localparam logic [SPAN_W-1:0] TOL_V    = SPAN_W'(TOL);
  localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(GOOD_RUN);

  logic              syncD;
  logic              syncRise;
  logic [GAP_W-1:0]  gapCnt;
  logic [SPAN_W-1:0] spacing;
  logic [SPAN_W-1:0] lineExt;
  logic [SPAN_W-1:0] lossLimit;
  logic              spanOk;
  logic              lossHit;
  logic [GOOD_W-1:0] goodCnt;
  logic [GOOD_W-1:0] goodNext;
  logic              effFree;
  logic              wantFree;

  assign syncRise  = syncIn & ~syncD;
  assign spacing   = {1'b0, gapCnt} + SPAN_W'(1);
  assign lineExt   = SPAN_W'(lineTotal);
  assign lossLimit = lineExt + lineExt;
  assign spanOk    = (spacing + TOL_V >= lineExt) && (spacing <= lineExt + TOL_V);
  assign lossHit   = !syncRise && (spacing >= lossLimit);
  assign goodNext  = (goodCnt == GOOD_TOP) ? GOOD_TOP : goodCnt + GOOD_W'(1);

  assign wantFree    = freerunSel | (autoFreeEn & sigLost);
  assign stb.syncHit = syncRise & ~effFree;
  assign stb.reload  = lineEnd | stb.syncHit;
  assign freeActive  = effFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncD  <= 1'b0;
      gapCnt <= GAP_MAX;
    end else begin
      syncD <= syncIn;
      if (syncRise)              gapCnt <= '0;
      else if (gapCnt != GAP_MAX) gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
      sigLost <= 1'b1;
    end else if (syncRise) begin
      if (spanOk) begin
        goodCnt <= goodNext;
        if (goodNext >= GOOD_TOP) sigLost <= 1'b0;
      end else begin
        goodCnt <= '0;
      end
    end else if (lossHit) begin
      goodCnt <= '0;
      sigLost <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           effFree <= 1'b1;
    else if (stb.reload) effFree <= wantFree;
  end

  // R6: mode in effect never moves between line boundaries
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.reload |=> $stable(freeActive));
  // R8: presence is only regained on a sync edge
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sigLost) |-> $past(syncRise));
  // R7: loss is only declared on a cycle without a sync edge
  p_loss_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sigLost) |-> !$past(syncRise));
endmodule

// File: rtl/hsync_dp.sv
module hsync_dp
  import hsync_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int PULSE_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  hsync_stb_t       stb,
  input  logic [CNT_W-1:0] lineTotal,
  input  logic             invertPol,
  output logic             lineEnd,
  output logic             hsyncOut
);
  localparam logic [CNT_W-1:0] PULSE_CNT = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] pixCnt;
  logic             pulseAct;

  assign lineEnd  = (pixCnt == lineTotal - CNT_W'(1));
  assign pulseAct = (pixCnt < PULSE_CNT);
  assign hsyncOut = pulseAct ^ invertPol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pixCnt <= '0;
    else if (stb.reload) pixCnt <= '0;
    else                 pixCnt <= pixCnt + CNT_W'(1);
  end

  // R2: the line wraps after its last programmed pixel
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pixCnt == lineTotal - CNT_W'(1)) && $stable(lineTotal) |=> pixCnt == '0);
  // R3: a locked sync restarts the line
  p_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.syncHit |=> pixCnt == '0);
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
  import hsync_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int PULSE_LEN = 64,
  parameter int TOL       = 16,
  parameter int GOOD_RUN  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             freerunSel,
  input  logic             autoFreeEn,
  input  logic             invertPol,
  input  logic [CNT_W-1:0] lineTotal,
  input  logic             syncIn,
  output logic             hsyncOut,
  output logic             freeActive,
  output logic             sigLost
);
  hsync_stb_t stb;
  logic       lineEnd;

  hsync_ctrl #(.CNT_W(CNT_W), .TOL(TOL), .GOOD_RUN(GOOD_RUN)) uCtrl (
    .clk(clk), .rstN(rstN), .freerunSel(freerunSel), .autoFreeEn(autoFreeEn),
    .lineTotal(lineTotal), .syncIn(syncIn), .lineEnd(lineEnd), .stb(stb),
    .freeActive(freeActive), .sigLost(sigLost)
  );

  hsync_dp #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .lineTotal(lineTotal),
    .invertPol(invertPol), .lineEnd(lineEnd), .hsyncOut(hsyncOut)
  );
endmodule

// File: tb/tb_hsync_gen.sv
module tb_hsync_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        freerunSel = 1'b1;
  logic        autoFreeEn = 1'b0;
  logic        invertPol = 1'b0;
  logic [11:0] lineTotal = 12'd200;
  logic        syncIn = 1'b0;
  logic        hsyncOut, freeActive, sigLost;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  hsync_gen dut (
    .clk(clk), .rstN(rstN), .freerunSel(freerunSel), .autoFreeEn(autoFreeEn),
    .invertPol(invertPol), .lineTotal(lineTotal), .syncIn(syncIn),
    .hsyncOut(hsyncOut), .freeActive(freeActive), .sigLost(sigLost)
  );

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] edges;
    logic        pol;
    logic        expOut;
  } vec_t;

  // freerun: output after N edges from reset release (R1, R2, R4, R10)
  localparam vec_t VECS [14] = '{
    '{16'd100, 16'd0,   1'b0, 1'b1},
    '{16'd100, 16'd63,  1'b0, 1'b1},
    '{16'd100, 16'd64,  1'b0, 1'b0},
    '{16'd100, 16'd99,  1'b0, 1'b0},
    '{16'd100, 16'd100, 1'b0, 1'b1},
    '{16'd100, 16'd164, 1'b0, 1'b0},
    '{16'd200, 16'd150, 1'b0, 1'b0},
    '{16'd200, 16'd199, 1'b0, 1'b0},
    '{16'd200, 16'd200, 1'b0, 1'b1},
    '{16'd200, 16'd263, 1'b1, 1'b0},
    '{16'd200, 16'd264, 1'b1, 1'b1},
    '{16'd80,  16'd80,  1'b0, 1'b1},
    '{16'd80,  16'd143, 1'b0, 1'b1},
    '{16'd80,  16'd144, 1'b0, 1'b0}
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic fr, input logic au, input logic pol, input logic [11:0] len);
    @(negedge clk);
    rstN = 1'b0; freerunSel = fr; autoFreeEn = au; invertPol = pol;
    lineTotal = len; syncIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; the next rising edge sees the sync rise
  task automatic doSync();
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
  endtask

  initial begin
    // vector table (R1, R2, R4)
    for (int i = 0; i < 14; i++) begin
      doReset(1'b1, 1'b0, VECS[i].pol, VECS[i].len[11:0]);
      waitEdges(int'(VECS[i].edges));
      check(hsyncOut, VECS[i].expOut, "R1/R2/R4 freerun vector");
    end

    // reset state (R10)
    doReset(1'b0, 1'b0, 1'b0, 12'd200);
    check(hsyncOut, 1'b1, "R10 output active");
    check(freeActive, 1'b1, "R10 freeActive");
    check(sigLost, 1'b1, "R10 sigLost");

    // locked entry at the first wrap (R6), no auto fallback (R9)
    waitEdges(199);
    check(freeActive, 1'b1, "R6 mode held before boundary");
    waitEdges(1);
    check(freeActive, 1'b0, "R6 locked after boundary");
    check(sigLost, 1'b1, "R9 still lost but locked");
    waitEdges(50);
    doSync();
    check(hsyncOut, 1'b1, "R3 pulse after sync");
    waitEdges(120);
    check(hsyncOut, 1'b0, "R3 mid line idle");
    doSync();
    check(hsyncOut, 1'b1, "R3 early sync re-times");
    waitEdges(63);
    check(hsyncOut, 1'b1, "R1 last active cycle");
    waitEdges(1);
    check(hsyncOut, 1'b0, "R1 pulse ends after 64");

    // switch to freerun at boundary only (R6), syncs ignored (R5)
    doSync();
    freerunSel = 1'b1;
    waitEdges(100);
    check(freeActive, 1'b0, "R6 request waits for boundary");
    waitEdges(100);
    check(freeActive, 1'b1, "R6 freerun at wrap");
    check(hsyncOut, 1'b1, "R2 wrap starts pulse");
    waitEdges(100);
    doSync();
    check(hsyncOut, 1'b0, "R5 sync ignored in freerun");

    // tolerance edges 184 and 216 accepted (R8)
    doReset(1'b0, 1'b1, 1'b0, 12'd200);
    doSync();
    waitEdges(183); doSync();
    waitEdges(215); doSync();
    waitEdges(199); doSync();
    check(sigLost, 1'b1, "R8 three spacings not enough");
    waitEdges(199); doSync();
    check(sigLost, 1'b0, "R8 cleared after four spacings");

    // out-of-window spacing restarts the run (R8)
    doReset(1'b0, 1'b1, 1'b0, 12'd200);
    doSync();
    waitEdges(199); doSync();
    waitEdges(199); doSync();
    waitEdges(216); doSync();
    waitEdges(199); doSync();
    waitEdges(199); doSync();
    check(sigLost, 1'b1, "R8 run restarted by 217 spacing");
    waitEdges(199); doSync();
    waitEdges(199); doSync();
    check(sigLost, 1'b0, "R8 cleared after fresh run");
    check(freeActive, 1'b1, "R9 auto freerun while lost");
    waitEdges(250);
    check(freeActive, 1'b0, "R9 locked once signal present");
    waitEdges(149);
    check(sigLost, 1'b0, "R7 no loss one edge early");
    waitEdges(1);
    check(sigLost, 1'b1, "R7 loss at two lines");
    waitEdges(200);
    check(freeActive, 1'b1, "R9 fallback to freerun");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule